// File: doc/BRIEF.md
# Programmable Power-of-Two Interval Timer

This block is a synchronous ripple-style binary counter built from equal sections. A slow input, `in1_i`, is sampled on the system clock, and each detected high-to-low transition steps the counter. A small select code picks one counter bit as the timer output. That bit is a divided-by-2^n square wave of the input, or it marks the end of a timed interval. A bypass control skips the lowest section, so the same select codes reach the finer divisions.

Two control pins start an interval. The clear input zeroes the chain and pulls the output low. The preset input zeroes the chain and latches the output high. The first input transition after preset releases pulls the output low and is not counted. When preset, clear and bypass are all high at once, the block enters a test arrangement. In that arrangement every section counts on its own, so the whole chain reaches all ones after only 2^SECT_W-1 transitions. A synchronized copy of the input is also brought out for cascading.

Top module: `pow2_timer`

## Requirements
- R1: In run mode (preset and clear low), `count_o` increases by exactly one, modulo 2^STAGES, for each falling edge of `in1_i`. It stays unchanged at all other times. The update appears three system clocks after the falling input is sampled.
- R2: With the output latch clear, `tout_o` equals `count_o[SECT_W + sel_i]`. With the defaults, code 0 gives bit 8 and code 15 gives bit 23.
- R3: With `bypass_i` high in run mode, the lowest SECT_W bits of `count_o` hold their value. Each input falling edge adds one to the bits above them, so select code k toggles every 2^k edges.
- R4: When `clear_i` is high outside test mode, `count_o` becomes zero and `tout_o` low on the next system clock, whatever the input and the state of preset.
- R5: When `preset_i` is high and `clear_i` low, `count_o` becomes zero and `tout_o` high. After preset falls, the first counted input edge drives `tout_o` low and leaves the count at zero. The second edge makes the count one.
- R6: While `inhib_i` is high, input falling edges change neither `count_o` nor the output latch.
- R7: With `preset_i`, `clear_i` and `bypass_i` all high (test mode), each SECT_W-bit section of `count_o` adds one, wrapping, on every input falling edge, all sections in parallel.
- R8: When the three test controls are released in the same cycle, with bypass low, the chain is one series counter again. An all-ones count rolls to zero on the next input falling edge.
- R9: With a fixed select code, `tout_o` is a square wave with 50% duty. It is high for 2^(SECT_W+sel) input edges and low for the same number.
- R10: `in1_buf_o` follows `in1_i` two system clocks later.
- R11: While `rst_n` is low, `count_o` is zero and `tout_o` and `in1_buf_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| in1_i | input | 1 | Timing input; falling edges step the counter |
| inhib_i | input | 1 | High blocks input edges from the chain |
| preset_i | input | 1 | Zero the chain and latch the output high |
| clear_i | input | 1 | Zero the chain and drive the output low |
| bypass_i | input | 1 | Skip the lowest section; with preset and clear selects test mode |
| sel_i | input | SEL_W | Tap select code |
| count_o | output | STAGES | Full counter state |
| tout_o | output | 1 | Selected tap or latched high level |
| in1_buf_o | output | 1 | Synchronized copy of the timing input |

## Verification
The bench builds the timer with three 4-bit sections, a 12-bit chain and a 3-bit select code. At that size the test-mode fill takes only 15 edges, and every tap, from bit 4 to bit 11, sits inside the same series of counted edges. Low taps go through several full square-wave periods, so both duty and period are checked. The all-ones to zero rollover is reached through test mode. Random mixes of edges, inhibit, bypass, select changes and preset/clear pulses are run against a bench model of the count and the output latch.

// File: rtl/pow2_timer_pkg.sv
package pow2_timer_pkg;

    typedef enum logic [1:0] {
        MODE_RUN    = 2'd0,
        MODE_CLEAR  = 2'd1,
        MODE_PRESET = 2'd2,
        MODE_TEST   = 2'd3
    } tmr_mode_e;

    // Test arrangement beats everything; clear beats preset otherwise.
    function automatic tmr_mode_e decode_mode(input logic preset, input logic clear,
                                              input logic bypass);
        if (preset && clear && bypass) return MODE_TEST;
        else if (clear)                return MODE_CLEAR;
        else if (preset)               return MODE_PRESET;
        else                           return MODE_RUN;
    endfunction

endpackage

// File: rtl/pow2_in_sync.sv
module pow2_in_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic sync_o,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = raw_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.s2;
    assign fall_o = sync_q.s3 & ~sync_q.s2;
endmodule

// File: rtl/pow2_stage_chain.sv
module pow2_stage_chain
    import pow2_timer_pkg::*;
#(
    parameter  int SECT_W   = 8,
    parameter  int NUM_SECT = 3,
    localparam int STAGES   = SECT_W * NUM_SECT,
    localparam int UPPER    = STAGES - SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_mode_e         mode_i,
    input  logic              bypass_i,
    input  logic              step_i,
    output logic [STAGES-1:0] cnt_o,
    output logic              hold_o
);
    typedef struct packed {
        logic [STAGES-1:0] cnt;
        logic              hold;
    } chain_t;

    chain_t chain_d, chain_q;

    logic [STAGES-1:0] cnt_par;
    logic [STAGES-1:0] cnt_ser;
    logic [STAGES-1:0] cnt_byp;
    logic [UPPER-1:0]  upper_inc;

    // Parallel section increments for the test arrangement.
    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        assign cnt_par[s*SECT_W +: SECT_W] = chain_q.cnt[s*SECT_W +: SECT_W] + SECT_W'(1);
    end

    assign cnt_ser   = chain_q.cnt + STAGES'(1);
    assign upper_inc = chain_q.cnt[STAGES-1:SECT_W] + UPPER'(1);
    assign cnt_byp   = {upper_inc, chain_q.cnt[SECT_W-1:0]};

    always_comb begin
        chain_d = chain_q;
        case (mode_i)
            MODE_TEST: begin
                chain_d.hold = 1'b0;
                if (step_i) chain_d.cnt = cnt_par;
            end
            MODE_CLEAR: begin
                chain_d.cnt  = '0;
                chain_d.hold = 1'b0;
            end
            MODE_PRESET: begin
                chain_d.cnt  = '0;
                chain_d.hold = 1'b1;
            end
            default: begin
                if (step_i) begin
                    if (chain_q.hold)  chain_d.hold = 1'b0;
                    else if (bypass_i) chain_d.cnt  = cnt_byp;
                    else               chain_d.cnt  = cnt_ser;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign cnt_o  = chain_q.cnt;
    assign hold_o = chain_q.hold;
endmodule

// File: rtl/pow2_tap_sel.sv
module pow2_tap_sel #(
    parameter  int UPPER = 16,
    parameter  int SEL_W = 4,
    localparam int NTAP  = 1 << SEL_W
) (
    input  logic [UPPER-1:0] upper_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             hold_i,
    output logic             tout_o
);
    logic [NTAP-1:0] taps;

    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        if (k < UPPER) begin : g_real
            assign taps[k] = upper_i[k];
        end else begin : g_pad
            assign taps[k] = 1'b0;
        end
    end

    assign tout_o = hold_i | taps[sel_i];
endmodule

// File: rtl/pow2_timer.sv
module pow2_timer
    import pow2_timer_pkg::*;
#(
    parameter  int SECT_W   = 8,
    parameter  int NUM_SECT = 3,
    localparam int STAGES   = SECT_W * NUM_SECT,
    localparam int UPPER    = STAGES - SECT_W,
    localparam int SEL_W    = $clog2(UPPER)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in1_i,
    input  logic              inhib_i,
    input  logic              preset_i,
    input  logic              clear_i,
    input  logic              bypass_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [STAGES-1:0] count_o,
    output logic              tout_o,
    output logic              in1_buf_o
);
    tmr_mode_e mode;
    logic      fall;
    logic      step;
    logic      hold;

    assign mode = decode_mode(preset_i, clear_i, bypass_i);
    assign step = fall & ~inhib_i;

    pow2_in_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (in1_i),
        .sync_o (in1_buf_o),
        .fall_o (fall)
    );

    pow2_stage_chain #(
        .SECT_W   (SECT_W),
        .NUM_SECT (NUM_SECT)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .bypass_i (bypass_i),
        .step_i   (step),
        .cnt_o    (count_o),
        .hold_o   (hold)
    );

    pow2_tap_sel #(
        .UPPER (UPPER),
        .SEL_W (SEL_W)
    ) u_tap (
        .upper_i (count_o[STAGES-1:SECT_W]),
        .sel_i   (sel_i),
        .hold_i  (hold),
        .tout_o  (tout_o)
    );

    // R1: no input edge in run mode, no count change
    a_r1_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && !fall) |=> $stable(count_o));

    // R4: clear outside test mode empties the chain and lowers the output
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !(preset_i && bypass_i)) |=> (count_o == '0 && !tout_o));

    // R5: preset raises the output
    a_r5_preset_high: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_i && !clear_i) |=> tout_o);

    // R5: the first edge after preset lowers the output without counting
    a_r5_first_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && hold && step) |=> (count_o == '0 && !tout_o));

    // R6: inhibit freezes the chain
    a_r6_inhibit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && inhib_i) |=> $stable(count_o));

    // R7: test arrangement only moves on input edges
    a_r7_test_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TEST && !fall) |=> $stable(count_o));
endmodule

// File: tb/sim_pow2_timer.sv
`timescale 1ns/1ps
module sim_pow2_timer;
    localparam int SW = 4;
    localparam int NS = 3;
    localparam int ST = SW * NS;
    localparam int SL = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in1 = 1'b0, inhib = 1'b0, preset = 1'b0, clear = 1'b0, bypass = 1'b0;
    logic [SL-1:0] sel = '0;
    logic [ST-1:0] count;
    logic          tout, in1_buf;

    logic [ST-1:0] m_cnt = '0;
    logic          m_hold = 1'b0;
    int            n_chk = 0, n_fail = 0, cyc = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    pow2_timer #(.SECT_W(SW), .NUM_SECT(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .in1_i(in1), .inhib_i(inhib), .preset_i(preset),
        .clear_i(clear), .bypass_i(bypass), .sel_i(sel), .count_o(count),
        .tout_o(tout), .in1_buf_o(in1_buf)
    );

    function automatic logic exp_tout(logic [ST-1:0] c, logic h, logic [SL-1:0] s);
        return h | c[SW + int'(s)];
    endfunction

    task automatic wait_neg(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [ST-1:0] ec, logic et);
        n_chk++;
        if (count !== ec || tout !== et) begin
            n_fail++;
            $display("FAIL %s: count=%h tout=%b expected count=%h tout=%b", req, count, tout, ec, et);
        end
    endtask

    task automatic check_model(string req);
        check(req, m_cnt, exp_tout(m_cnt, m_hold, sel));
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic model_step();
        if (inhib) return;
        if (preset && clear && bypass) begin
            for (int s = 0; s < NS; s++) m_cnt[s*SW +: SW] = m_cnt[s*SW +: SW] + 1'b1;
        end else if (!preset && !clear) begin
            if (m_hold) m_hold = 1'b0;
            else if (bypass) m_cnt[ST-1:SW] = m_cnt[ST-1:SW] + 1'b1;
            else m_cnt = m_cnt + 1'b1;
        end
    endtask

    task automatic pulse_edge();
        in1 = 1'b1;
        wait_neg(4);
        in1 = 1'b0;
        wait_neg(5);
        model_step();
    endtask

    task automatic do_clear();
        clear = 1'b1;
        wait_neg(2);
        m_cnt = '0; m_hold = 1'b0;
        check_model("R4 clear");
        clear = 1'b0;
        wait_neg(1);
    endtask

    task automatic do_preset();
        preset = 1'b1;
        wait_neg(2);
        m_cnt = '0; m_hold = 1'b1;
        check_model("R5 preset");
        preset = 1'b0;
        wait_neg(1);
    endtask

    task automatic finish_run();
        if (done) return;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: cycles=%0d expected completion before %0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5eed_2024));
        wait_neg(4);
        check("R11 reset", '0, 1'b0);
        check_bit("R11 buf", in1_buf, 1'b0);
        rst_n = 1'b1;
        wait_neg(2);

        // R10: buffered copy lags by two clocks
        in1 = 1'b1;
        wait_neg(1);
        check_bit("R10 lag1", in1_buf, 1'b0);
        wait_neg(1);
        check_bit("R10 lag2", in1_buf, 1'b1);
        wait_neg(2);
        in1 = 1'b0;
        wait_neg(5);
        model_step();
        check("R1 first", 12'h001, 1'b0);

        // R9 / R2: square wave on tap 0 (bit 4)
        for (int n = 0; n < 40; n++) begin
            pulse_edge();
            check("R9 square", m_cnt, ((m_cnt >> SW) & 1) != 0);
        end
        sel = 3'd1;
        wait_neg(1);
        check_model("R2 tap1");

        do_clear();
        // R4: clear beats preset outside test mode
        preset = 1'b1; clear = 1'b1;
        wait_neg(2);
        check("R4 priority", '0, 1'b0);
        preset = 1'b0; clear = 1'b0;
        wait_neg(1);

        // R5: first edge lowers, second counts
        sel = 3'd0;
        do_preset();
        check("R5 held high", '0, 1'b1);
        pulse_edge();
        check("R5 first edge", '0, 1'b0);
        pulse_edge();
        check("R5 second edge", 12'h001, 1'b0);

        // R6: inhibit holds count and latch
        inhib = 1'b1;
        for (int n = 0; n < 3; n++) begin
            pulse_edge();
            check("R6 inhibit", 12'h001, 1'b0);
        end
        do_preset();
        pulse_edge();
        check("R6 latch held", '0, 1'b1);
        inhib = 1'b0;
        pulse_edge();
        check("R6 released", '0, 1'b0);

        // R3: bypass skips the low section
        bypass = 1'b1;
        do_clear();
        for (int n = 1; n <= 10; n++) begin
            pulse_edge();
            check("R3 bypass", ST'(n << SW), (n & 1) != 0);
        end

        // R7: test mode fills every section
        bypass = 1'b0;
        do_clear();
        preset = 1'b1; clear = 1'b1; bypass = 1'b1;
        wait_neg(2);
        check("R7 enter", '0, 1'b0);
        for (int n = 1; n <= 15; n++) begin
            pulse_edge();
            if (n == 7)  check("R7 mid", 12'h777, 1'b1);
            if (n == 15) check("R7 full", 12'hFFF, 1'b1);
        end

        // R8: back to series, one edge rolls over
        preset = 1'b0; clear = 1'b0; bypass = 1'b0;
        wait_neg(2);
        check("R8 exit", 12'hFFF, 1'b1);
        pulse_edge();
        check("R8 rollover", '0, 1'b0);

        // Random mix against the model
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op <= 5) begin
                pulse_edge();
                check_model("R1 random edge");
            end else if (op == 6) begin
                inhib = ~inhib;
                wait_neg(1);
                check_model("R6 random inhibit");
            end else if (op == 7) begin
                sel = SL'($urandom_range(0, 7));
                wait_neg(1);
                check_model("R2 random select");
            end else if (op == 8) begin
                bypass = ~bypass;
                wait_neg(1);
                check_model("R3 random bypass");
            end else begin
                if ($urandom_range(0, 1) == 0) do_preset();
                else do_clear();
            end
        end

        finish_run();
    end
endmodule